// File: doc/BRIEF.md
# Masked Pin-Change Interrupt Detector

This block watches a group of general-purpose pins and raises one shared interrupt flag whenever a pin that software has enabled changes level. Rising and falling transitions count the same way. A pin also counts when the chip itself drives it as an output, so software can use this to raise an interrupt on purpose.

Each pin first passes through a level-sensitive capture latch and then a clocked sampling register. A pin has changed when the captured level differs from the sampled level. The per-pin differences are filtered by an enable mask and merged into a single bit. That bit goes through a registered merge stage and a registered set stage, and the set stage then loads the sticky flag. The path from a toggle to the flag therefore has a fixed number of clock edges.

A separate wake request is formed without any register on its path. It compares the live pin levels with the last sampled levels under the mask. Because of this it can still signal a change when the clock is stopped in deep sleep. Software reads the flag and acknowledges it with a one-cycle clear strobe.

Top module: `pin_change_detect`

## Requirements
- R1: After reset is released with the pins held steady, the flag reads 0 and the wake request reads 0, whatever the pin levels and mask.
- R2: A rising toggle on an enabled pin that is applied while the clock is high, after rising edge N, makes the flag read 1 after rising edge N+3 and not before; the flag is still 0 after edge N+2.
- R3: A falling toggle on an enabled pin sets the flag with the same latency as in R2.
- R4: A pin whose mask bit is 0 never sets the flag and never raises the wake request. Bit i of the mask enables bit i of the pin bus.
- R5: Once set, the flag stays 1 until the clear strobe is sampled high on a rising edge, and it reads 0 after that edge.
- R6: When a set event and a clear strobe are sampled on the same rising edge, the flag reads 1 after that edge.
- R7: One toggle produces exactly one set event. If the flag is cleared after it has been set, it stays 0 until a later toggle.
- R8: The wake request goes to 1 with no clock edge as soon as an enabled pin differs from its last sampled level, including while the clock is stopped. It returns to 0 once the clock has sampled the new level.
- R9: Each of the six pin inputs can set the flag on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its low phase opens the capture latches |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | 6 | Monitored pin levels |
| mask_i | input | 6 | Per-pin enable, 1 = pin contributes |
| clr_i | input | 1 | One-cycle flag clear strobe |
| flag_o | output | 1 | Sticky pin-change flag |
| wake_o | output | 1 | Unclocked wake request from any enabled pin difference |

## Verification
A set event arriving from the pipeline and a clear strobe from software can land on the same rising edge. The bench provokes this by toggling a pin and then raising the clear strobe exactly two edges later, so that the clear is sampled on the same edge as the set stage. It judges the result by requiring the flag to read 1 after that edge, and then by requiring a second, lone clear to drop it.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  localparam int unsigned PCD_MAXW = 32;

  // OR of all bit differences that are enabled.
  function automatic logic any_masked(input logic [PCD_MAXW-1:0] a,
                                      input logic [PCD_MAXW-1:0] b,
                                      input logic [PCD_MAXW-1:0] en);
    return |((a ^ b) & en);
  endfunction

  // Next state of the sticky flag: a set has priority over a clear.
  function automatic logic flag_next(input logic set_evt,
                                     input logic clr,
                                     input logic cur);
    if (set_evt) return 1'b1;
    if (clr)     return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/pcd_pin_stage.sv
module pcd_pin_stage #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lat_o,
  output logic [W-1:0] sync_o
);

  // Latch enable comes from the clock phase: open while the clock is low.
  logic lat_en;
  assign lat_en = ~clk;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic lat_q;
    logic sync_q;

    always_latch begin
      if (lat_en) lat_q <= pin_i[i];
    end

    always_ff @(posedge clk) begin
      sync_q <= lat_q;
    end

    assign lat_o[i]  = lat_q;
    assign sync_o[i] = sync_q;
  end

endmodule

// File: rtl/pcd_merge.sv
module pcd_merge #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lat_i,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] mask_i,
  output logic         chg_any_o
);
  import pcd_pkg::*;

  logic diff_any;
  assign diff_any = any_masked(PCD_MAXW'(lat_i), PCD_MAXW'(sync_i),
                               PCD_MAXW'(mask_i));

  always_ff @(posedge clk) begin
    if (!rst_n) chg_any_o <= 1'b0;
    else        chg_any_o <= diff_any;
  end

endmodule

// File: rtl/pcd_flag.sv
module pcd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic chg_any_i,
  input  logic clr_i,
  output logic set_evt_o,
  output logic flag_o
);
  import pcd_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_evt_o <= 1'b0;
      flag_o    <= 1'b0;
    end else begin
      set_evt_o <= chg_any_i;
      flag_o    <= flag_next(set_evt_o, clr_i, flag_o);
    end
  end

endmodule

// File: rtl/pin_change_detect.sv
module pin_change_detect #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  output logic         flag_o,
  output logic         wake_o
);
  import pcd_pkg::*;

  logic [W-1:0] lat_vec;
  logic [W-1:0] sync_vec;
  logic         chg_any;
  logic         set_evt;

  pcd_pin_stage #(.W(W)) u_pins (
    .clk    (clk),
    .pin_i  (pins_i),
    .lat_o  (lat_vec),
    .sync_o (sync_vec)
  );

  pcd_merge #(.W(W)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .lat_i     (lat_vec),
    .sync_i    (sync_vec),
    .mask_i    (mask_i),
    .chg_any_o (chg_any)
  );

  pcd_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .chg_any_i (chg_any),
    .clr_i     (clr_i),
    .set_evt_o (set_evt),
    .flag_o    (flag_o)
  );

  // Unclocked wake path: live pins against last sampled levels.
  assign wake_o = any_masked(PCD_MAXW'(pins_i), PCD_MAXW'(sync_vec),
                             PCD_MAXW'(mask_i));

endmodule

// File: rtl/pin_change_detect_checker.sv
module pin_change_detect_checker #(
  parameter int unsigned W = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] mask_i,
  input logic         clr_i,
  input logic         flag_o,
  input logic         wake_o,
  input logic         chg_any,
  input logic         set_evt
);

  assert_set_loads_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_o);

  assert_set_follows_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |-> $past(chg_any));

  assert_masked_no_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_i) == '0) |-> !chg_any);

  assert_masked_no_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |-> !wake_o);

  assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && clr_i && !set_evt) |=> !flag_o);

  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && clr_i) |=> flag_o);

  assert_rise_needs_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_evt));

endmodule

bind pin_change_detect pin_change_detect_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mask_i  (mask_i),
  .clr_i   (clr_i),
  .flag_o  (flag_o),
  .wake_o  (wake_o),
  .chg_any (chg_any),
  .set_evt (set_evt)
);

// File: tb/tb_pin_change_detect.sv
`timescale 1ns/100ps
module tb_pin_change_detect;

  localparam int W = 6;

  logic         clk = 1'b0;
  logic         clk_run = 1'b1;
  logic         rst_n;
  logic [W-1:0] pins;
  logic [W-1:0] mask;
  logic         clr;
  logic         flag;
  logic         wake;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  typedef struct {
    int    at;
    logic  val;
    string tag;
  } exp_t;
  exp_t sb[$];

  pin_change_detect #(.W(W)) dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_i (pins),
    .mask_i (mask),
    .clr_i  (clr),
    .flag_o (flag),
    .wake_o (wake)
  );

  // 250 MHz; when stopped, the clock settles low.
  always #2 if (clk_run || clk) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: compare the flag against scoreboard entries mid-cycle.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      if (e.at == cyc) check(e.tag, flag, e.val);
      else begin
        n_checks++; n_fail++;
        $display("FAIL %s: entry for cycle %0d missed, got - expected %b",
                 e.tag, e.at, e.val);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Driver: toggle pin i now (clock high) and push the expected flag timeline.
  task automatic toggle_push(input int i, input string tag);
    pins[i] = ~pins[i];
    #0.5;
    check({tag, " wake"}, wake, 1'b1);
    sb.push_back('{cyc + 2, 1'b0, {tag, " not early"}});
    sb.push_back('{cyc + 3, 1'b1, {tag, " latency"}});
  endtask

  task automatic clear_flag();
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
  endtask

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pins  = 6'b101010;
    mask  = '0;
    clr   = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check("R1 flag after reset", flag, 1'b0);
    check("R1 wake after reset", wake, 1'b0);
    mask = '1;
    #0.5;
    check("R1 wake with mask on", wake, 1'b0);
    tick(3);
    check("R1 flag steady pins", flag, 1'b0);

    // Rising toggle on pin 0 (0 -> 1)
    toggle_push(0, "R2 rise pin0");
    tick(4);
    check("R8 wake drops after sampling", wake, 1'b0);
    tick(2);
    check("R5 flag held", flag, 1'b1);
    clear_flag();
    check("R5 flag cleared", flag, 1'b0);
    tick(5);
    check("R7 no second set", flag, 1'b0);

    // Falling toggle on pin 1 (1 -> 0)
    toggle_push(1, "R3 fall pin1");
    tick(5);
    clear_flag();
    check("R3 cleared", flag, 1'b0);

    // Masked-off pin
    mask = 6'b111110;
    tick(1);
    pins[0] = ~pins[0];
    #0.5;
    check("R4 masked wake", wake, 1'b0);
    for (int k = 0; k < 5; k++) begin
      tick(1);
      check("R4 masked flag", flag, 1'b0);
    end
    mask = '1;
    tick(4);
    check("R4 re-enable no spurious", flag, 1'b0);

    // Set and clear on the same edge
    toggle_push(2, "R6 toggle");
    tick(2);
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    check("R6 set wins over clear", flag, 1'b1);
    tick(1);
    clear_flag();
    check("R6 later clear", flag, 1'b0);

    // Every pin individually
    for (int i = 0; i < W; i++) begin
      toggle_push(i, $sformatf("R9 pin%0d", i));
      tick(5);
      clear_flag();
      tick(1);
    end

    // Wake with clock stopped
    clk_run = 1'b0;
    #10;
    pins[3] = ~pins[3];
    #1;
    check("R8 wake clock stopped", wake, 1'b1);
    check("R8 flag waits for clock", flag, 1'b0);
    #5;
    clk_run = 1'b1;
    tick(5);
    check("R8 flag after restart", flag, 1'b1);
    check("R8 wake cleared after restart", wake, 1'b0);
    clear_flag();

    tick(3);
    check("R7 scoreboard drained", logic'(sb.size() == 0), 1'b1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule